// File: doc/BRIEF.md
# Input Capture and Output Compare Timer

A 16-bit free-running counter peripheral reached through a byte-wide register bus. The counter advances on each cycle in which `tick_en` is high. On a selected transition of `cap_in` it stores the counter value in a capture register. When the counter steps onto the value in a compare register, it drives a programmed level onto `cmp_out`. It also flags the counter's wrap from all ones to zero. Three event flags, each gated by its own enable, combine into one interrupt line.

Software reads the counter high byte first. That read freezes the low byte, so the two reads form one coherent 16-bit value. A flag is cleared by a two-access handshake. First, software reads the status register while the flag is set. Then it accesses the low byte that belongs to that flag. Only the flags seen as set at the status read can be cleared by the access that follows. Reset returns the counter, the enables and the compare pin to known values. It leaves the three flags and the capture edge selection as they were.

Read data on `rdata` follows `addr` combinationally. Read side effects (arming, clearing, latching) take place at the rising edge on which `rd` is high. Writes take effect at the rising edge on which `wr` is high.

Top module: `capcmp_timer`

## Requirements
- R1: Synchronous reset loads the counter with 16'hFFFC. Each rising edge with `tick_en` high adds one to the counter, wrapping from 16'hFFFF to 16'h0000. With `tick_en` low the counter holds.
- R2: Address 8'h18 reads counter bits 15:8. Address 8'h19 reads counter bits 7:0. A read of 8'h18 latches the current low byte, and each later read of 8'h19 returns that latched byte until one read of 8'h19 releases the latch. Writes to 8'h18 and 8'h19 change nothing.
- R3: The control register at 8'h12 is read/write. Bit 7 enables the capture interrupt, bit 6 enables the compare interrupt, bit 5 enables the overflow interrupt, bit 1 selects the capture edge (1 rising, 0 falling) and bit 0 is the compare output level. Bits 4:2 read 0. Reset clears bits 7, 6, 5 and 0 and keeps bit 1.
- R4: `cap_in` passes through a two-flop synchronizer. On a synchronized transition of the selected polarity, the counter value is copied into the capture register (8'h14 high byte, 8'h15 low byte, both read-only) and the capture flag sets.
- R5: The compare register is read/write, with its high byte at 8'h16 and its low byte at 8'h17, and resets to 16'hFFFF. When the counter advances onto a value equal to the compare register, on that same edge `cmp_out` takes the level in control bit 0 and the compare flag sets. `cmp_out` resets to 0.
- R6: The overflow flag sets on the edge where the counter wraps from 16'hFFFF to 16'h0000.
- R7: The status register at 8'h13 is read-only. Bit 7 is the capture flag, bit 6 the compare flag and bit 5 the overflow flag. Bits 4:0 read 0. Reset leaves the three flags unchanged.
- R8: A flag clears only on a read of its low byte (8'h15 for capture, 8'h19 for overflow) after a status read that found that flag set. A status read that found the flag clear does not arm it. A new event in the same cycle as the clearing access keeps the flag set.
- R9: Once the compare flag is armed by a status read, a write to 8'h17 clears it in the same way a read of 8'h17 does.
- R10: `irq` is high exactly when some flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| addr | input | 8 | Register address |
| rd | input | 1 | Read strobe; side effects at the rising edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
`rdata` follows `addr` in the same cycle. The counter, the compare pin, the flags, the latch and the arming state change on the rising edge that sees the strobe, tick or match, so they show one cycle later. A capture appears only after the third rising edge that follows a change on `cap_in`, because of the two synchronizer flops and the edge-detect stage. The bench drives its inputs 2 ns after each rising edge. It updates its behavioural model at the rising edge and compares `rdata`, `cmp_out` and `irq` at the falling edge, so every result is sampled in the half cycle after the edge that produced it.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] A_CTL  = 'h12,
  parameter logic [AW-1:0] A_STS  = 'h13,
  parameter logic [AW-1:0] A_ICH  = 'h14,
  parameter logic [AW-1:0] A_ICL  = 'h15,
  parameter logic [AW-1:0] A_CMPH = 'h16,
  parameter logic [AW-1:0] A_CMPL = 'h17,
  parameter logic [AW-1:0] A_CNTH = 'h18,
  parameter logic [AW-1:0] A_CNTL = 'h19,
  parameter logic [2*DW-1:0] CNT_RST = 'hFFFC,
  parameter logic [2*DW-1:0] CMP_RST = 'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cap_in,
  output logic          cmp_out,
  output logic          irq
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt, cnt_nx, icr, ocr;
  logic [DW-1:0] lat;
  logic          lat_v;
  logic          ie_ic, ie_oc, ie_to, edge_sel, olvl;
  logic          icf, ocf, tof, arm_ic, arm_oc, arm_to;
  logic [2:0]    sync;
  logic          cap_ev, cmp_ev, ovf_ev;
  logic          rd_sts, acc_icl, acc_cmpl, rd_cntl, rd_cnth;
  logic          clr_ic, clr_oc, clr_to;

  assign cnt_nx   = cnt + 1'b1;
  assign cap_ev   = edge_sel ? (sync[1] & ~sync[2]) : (~sync[1] & sync[2]);
  assign cmp_ev   = tick_en && (cnt_nx == ocr);
  assign ovf_ev   = tick_en && (&cnt);

  assign rd_sts   = rd && (addr == A_STS);
  assign acc_icl  = rd && (addr == A_ICL);
  assign acc_cmpl = (rd || wr) && (addr == A_CMPL);
  assign rd_cntl  = rd && (addr == A_CNTL);
  assign rd_cnth  = rd && (addr == A_CNTH);

  assign clr_ic   = arm_ic && acc_icl;
  assign clr_oc   = arm_oc && acc_cmpl;
  assign clr_to   = arm_to && rd_cntl;

  assign irq = (icf & ie_ic) | (ocf & ie_oc) | (tof & ie_to);

  // counter, synchronizer, capture/compare registers, pin, latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CNT_RST;
      sync    <= '0;
      icr     <= '0;
      ocr     <= CMP_RST;
      cmp_out <= 1'b0;
      lat     <= '0;
      lat_v   <= 1'b0;
    end else begin
      sync <= {sync[1:0], cap_in};
      if (tick_en) cnt <= cnt_nx;
      if (cap_ev) icr <= cnt;
      if (cmp_ev) cmp_out <= olvl;
      if (wr && addr == A_CMPH) ocr[CW-1:DW] <= wdata;
      if (wr && addr == A_CMPL) ocr[DW-1:0]  <= wdata;
      if (rd_cnth) begin
        lat   <= cnt[DW-1:0];
        lat_v <= 1'b1;
      end else if (rd_cntl) begin
        lat_v <= 1'b0;
      end
    end
  end

  // control bits that reset clears
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ie_ic, ie_oc, ie_to, olvl} <= '0;
      {arm_ic, arm_oc, arm_to}    <= '0;
    end else begin
      if (wr && addr == A_CTL) begin
        ie_ic <= wdata[DW-1];
        ie_oc <= wdata[DW-2];
        ie_to <= wdata[DW-3];
        olvl  <= wdata[0];
      end
      if (rd_sts) begin
        arm_ic <= icf;
        arm_oc <= ocf;
        arm_to <= tof;
      end else begin
        if (acc_icl)  arm_ic <= 1'b0;
        if (acc_cmpl) arm_oc <= 1'b0;
        if (rd_cntl)  arm_to <= 1'b0;
      end
    end
  end

  // state that reset leaves alone
  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (wr && addr == A_CTL) edge_sel <= wdata[1];
      if (cap_ev)      icf <= 1'b1;
      else if (clr_ic) icf <= 1'b0;
      if (cmp_ev)      ocf <= 1'b1;
      else if (clr_oc) ocf <= 1'b0;
      if (ovf_ev)      tof <= 1'b1;
      else if (clr_to) tof <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = {ie_ic, ie_oc, ie_to, {(DW-5){1'b0}}, edge_sel, olvl};
      A_STS:   rdata = {icf, ocf, tof, {(DW-3){1'b0}}};
      A_ICH:   rdata = icr[CW-1:DW];
      A_ICL:   rdata = icr[DW-1:0];
      A_CMPH:  rdata = ocr[CW-1:DW];
      A_CMPL:  rdata = ocr[DW-1:0];
      A_CNTH:  rdata = cnt[CW-1:DW];
      A_CNTL:  rdata = lat_v ? lat : cnt[DW-1:0];
      default: rdata = '0;
    endcase
  end

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick_en)) |-> (cnt == $past(cnt) + 1'b1));
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick_en)) |-> $stable(cnt));
  assert_icr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(icr)) |-> icf);
  assert_pin_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(cmp_out)) |-> (cnt == $past(ocr)));
  assert_tof_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(tof)) |-> ($past(tick_en) && cnt == '0));
  assert_icf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(icf) |-> ($past(rd) && $past(addr) == A_ICL));
  assert_ocf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ocf) |-> ($past(rd || wr) && $past(addr) == A_CMPL));
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (icf || ocf || tof));
endmodule

// File: tb/sim_capcmp_timer.sv
module sim_capcmp_timer;
  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, rd = 1'b0, wr = 1'b0, cap_in = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       cmp_out, irq;

  always #10 clk = ~clk;

  capcmp_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .rd(rd),
                   .wr(wr), .wdata(wdata), .rdata(rdata), .cap_in(cap_in),
                   .cmp_out(cmp_out), .irq(irq));

  int vectors = 0, misses = 0;
  bit synced = 0, done = 0;

  // behavioural model
  logic [15:0] m_cnt, m_icr, m_ocr;
  logic [7:0]  m_lat;
  bit          m_latv, m_edge, m_olvl, m_pin;
  bit [2:0]    m_ie;
  bit          f_ic, f_oc, f_to, a_ic, a_oc, a_to;
  bit          hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit ce, me, oe, c_ic, c_oc, c_to;
    if (!rst_n) begin
      m_cnt = 16'hFFFC; m_ocr = 16'hFFFF; m_icr = 16'h0000;
      m_ie = 3'b000; m_olvl = 0; m_pin = 0; m_latv = 0; m_lat = 8'h00;
      a_ic = 0; a_oc = 0; a_to = 0;
      hist = '{0, 0, 0};
    end else begin
      ce = m_edge ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]);
      me = tick_en && (16'(m_cnt + 16'd1) == m_ocr);
      oe = tick_en && (m_cnt == 16'hFFFF);
      c_ic = a_ic && rd && addr == 8'h15;
      c_oc = a_oc && (rd || wr) && addr == 8'h17;
      c_to = a_to && rd && addr == 8'h19;
      if (rd && addr == 8'h13) begin
        a_ic = f_ic; a_oc = f_oc; a_to = f_to;
      end else begin
        if (rd && addr == 8'h15) a_ic = 0;
        if ((rd || wr) && addr == 8'h17) a_oc = 0;
        if (rd && addr == 8'h19) a_to = 0;
      end
      f_ic = ce ? 1'b1 : (c_ic ? 1'b0 : f_ic);
      f_oc = me ? 1'b1 : (c_oc ? 1'b0 : f_oc);
      f_to = oe ? 1'b1 : (c_to ? 1'b0 : f_to);
      if (ce) m_icr = m_cnt;
      if (me) m_pin = m_olvl;
      if (rd && addr == 8'h18) begin m_lat = m_cnt[7:0]; m_latv = 1; end
      else if (rd && addr == 8'h19) m_latv = 0;
      if (wr && addr == 8'h12) begin m_ie = wdata[7:5]; m_edge = wdata[1]; m_olvl = wdata[0]; end
      if (wr && addr == 8'h16) m_ocr[15:8] = wdata;
      if (wr && addr == 8'h17) m_ocr[7:0] = wdata;
      if (tick_en) m_cnt = m_cnt + 16'd1;
      hist.push_front(cap_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h12: return {m_ie, 3'b000, m_edge, m_olvl};
      8'h13: return {f_ic, f_oc, f_to, 5'b00000};
      8'h14: return m_icr[15:8];
      8'h15: return m_icr[7:0];
      8'h16: return m_ocr[15:8];
      8'h17: return m_ocr[7:0];
      8'h18: return m_cnt[15:8];
      8'h19: return m_latv ? m_lat : m_cnt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h12: return "R3";
      8'h13: return "R7/R8";
      8'h14, 8'h15: return "R4";
      8'h16, 8'h17: return "R5/R9";
      8'h18, 8'h19: return "R1/R2";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag, string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s at %0t: got %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (synced && !done) begin
    chk(rdata, exp_rd(addr), tag_of(addr), $sformatf("rdata@%h", addr));
    chk({7'd0, cmp_out}, {7'd0, m_pin}, "R5", "cmp_out");
    chk({7'd0, irq}, {7'd0, |({f_ic, f_oc, f_to} & m_ie)}, "R10", "irq");
  end

  task automatic cyc(); @(posedge clk); #2; endtask
  task automatic idle(int n); rd = 0; wr = 0; repeat (n) cyc(); endtask
  task automatic rdreg(logic [7:0] a); addr = a; rd = 1; wr = 0; cyc(); rd = 0; endtask
  task automatic wrreg(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; rd = 0; cyc(); wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; vectors++; misses++;
      $display("FAIL watchdog expired: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    cyc(); rst_n = 0; repeat (3) cyc(); rst_n = 1;
    wrreg(8'h12, 8'h02);
    addr = 8'h13;
    @(negedge clk);
    f_ic = rdata[7]; f_oc = rdata[6]; f_to = rdata[5];
    synced = 1;
    cyc();
    // reset values: counter FFFC, compare FFFF (R1, R5)
    rdreg(8'h18); rdreg(8'h19); rdreg(8'h16); rdreg(8'h17); rdreg(8'h12);
    // R1 R6 wrap sets overflow, compare at FFFF fires with level 0
    tick_en = 1; idle(8);
    // R8 two-step clear of overflow and compare flags
    rdreg(8'h19); rdreg(8'h13); rdreg(8'h19); rdreg(8'h17); rdreg(8'h13);
    // R5 compare with level 1 and all interrupts enabled
    wrreg(8'h16, 8'h00); wrreg(8'h17, 8'h40); wrreg(8'h12, 8'hE3);
    idle(80); rdreg(8'h13);
    // R9 low-byte write clears armed compare flag
    wrreg(8'h17, 8'h30); rdreg(8'h13); wrreg(8'h17, 8'h30);
    // R4 rising-edge capture and its latency
    cap_in = 1; addr = 8'h15; idle(5); rdreg(8'h14); rdreg(8'h15);
    rdreg(8'h13); rdreg(8'h15);
    // R4 falling edge ignored while rising selected
    cap_in = 0; addr = 8'h13; idle(5);
    // R8 status read with capture flag clear does not arm it
    wrreg(8'h12, 8'hE1); rdreg(8'h13);
    cap_in = 1; idle(4); cap_in = 0; addr = 8'h14; idle(5);
    rdreg(8'h15); rdreg(8'h13); rdreg(8'h15);
    // R2 coherent read and ignored writes
    rdreg(8'h18); idle(5); addr = 8'h19; idle(2); rdreg(8'h19); rdreg(8'h19);
    wrreg(8'h18, 8'h55); wrreg(8'h19, 8'hAA); idle(3);
    rdreg(8'h18); rdreg(8'h18); rdreg(8'h19);
    // R3 pad bits read zero
    wrreg(8'h12, 8'hFF); rdreg(8'h12);
    // R1 irregular tick pattern
    for (int i = 0; i < 60; i++) begin tick_en = (i % 3) != 0; addr = 8'h19; cyc(); end
    tick_en = 1;
    // R3 R7 mid-run reset keeps flags and edge select
    rdreg(8'h13); rst_n = 0; addr = 8'h13; cyc(); cyc(); rst_n = 1;
    addr = 8'h12; idle(2); addr = 8'h13; idle(2);
    // R5 R6 R10 long run through a full wrap with overflow interrupt only
    wrreg(8'h12, 8'h20); wrreg(8'h16, 8'h00); wrreg(8'h17, 8'h30);
    addr = 8'h13; idle(66000);
    rdreg(8'h13); rdreg(8'h19); rdreg(8'h17); idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule